// File: doc/BRIEF.md
# ASCII Matrix Stream Parser

This block takes a byte stream of plain ASCII text that describes a two-dimensional matrix of unsigned decimal integers, one matrix row per text line. Digits are folded into a binary value as they arrive, so no character buffer is kept. Each finished number is written to an on-chip memory through a simple write port, at consecutive addresses in row-major order.

The shape of the matrix is taken from the text itself. Entries on a line are counted to give the column count, and non-empty lines are counted to give the row count. An end-of-file character, or a pulse on a dedicated end-of-stream input, finishes the matrix and raises a done flag. Malformed text raises a sticky error flag. Malformed text means an unexpected character, or a line whose entry count differs from the first line.

Top module: `ascii_matrix_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_we, mem_addr, mem_wdata, col_count, row_count, done and error are all zero.
- R2: Digit bytes 0x30 to 0x39 build a decimal value. A separator byte, space 0x20 or comma 0x2C, that follows digits writes that value: mem_we is high for exactly one cycle, in the cycle after the separator is accepted, with mem_wdata holding the value.
- R3: A value above 65535 is written as 65535, for VAL_W = 16.
- R4: Writes go to addresses 0, 1, 2 and so on, so entry (row, column) lands at row x col_count + column. Separators with no digits between them write nothing.
- R5: A line feed 0x0A writes any pending value and closes the line. The entry count of the first non-empty line becomes col_count. row_count rises by one for each non-empty line. Empty lines change nothing.
- R6: A carriage return 0x0D has no effect.
- R7: A closed line whose entry count differs from col_count sets error. error stays set until reset.
- R8: Any other byte sets error and is skipped. Digits on both sides of it join into one value.
- R9: End of file is either byte 0x04 or in_eos high. It writes any pending value, closes a non-empty line, and sets done in the next cycle. When in_eos and in_valid are high together, the byte is dropped.
- R10: Once done is high, every input is ignored until reset. There are no writes, and the counts and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte holds a character this cycle |
| in_byte | input | 8 | ASCII character |
| in_eos | input | 1 | End of stream, same effect as 0x04 |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | VAL_W | Value to store |
| col_count | output | DIM_W | Entries per row, latched at the first row |
| row_count | output | DIM_W | Completed non-empty rows |
| done | output | 1 | Matrix complete |
| error | output | 1 | Malformed text seen (sticky) |

## Verification
Several events can fall on a single accepted byte. A line feed or end-of-file that follows digits must write the last value, close the row and update the counts all on the same edge. A simultaneous in_eos and digit byte must keep the EOF and drop the digit. The bench ends lines and streams directly after digits and pulses in_eos together with a valid digit. It then judges the captured writes and the final counts against values derived from the input text.

// File: rtl/amp_pkg.sv
package amp_pkg;

    typedef enum logic [2:0] {
        CC_NONE  = 3'd0,
        CC_DIGIT = 3'd1,
        CC_SEP   = 3'd2,
        CC_NL    = 3'd3,
        CC_IGN   = 3'd4,
        CC_EOF   = 3'd5,
        CC_BAD   = 3'd6
    } char_class_e;

    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_NINE  = 8'h39;
    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_COMMA = 8'h2C;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_EOT   = 8'h04;

    function automatic char_class_e classify(input logic [7:0] ch);
        if (ch >= CH_ZERO && ch <= CH_NINE)       return CC_DIGIT;
        else if (ch == CH_SPACE || ch == CH_COMMA) return CC_SEP;
        else if (ch == CH_LF)                      return CC_NL;
        else if (ch == CH_CR)                      return CC_IGN;
        else if (ch == CH_EOT)                     return CC_EOF;
        else                                       return CC_BAD;
    endfunction

endpackage

// File: rtl/amp_classify.sv
module amp_classify
    import amp_pkg::*;
(
    input  logic [7:0]  ch,
    output char_class_e cls,
    output logic [3:0]  digit
);
    logic [7:0] offset;

    always_comb begin
        cls    = classify(ch);
        offset = ch - CH_ZERO;
        digit  = (cls == CC_DIGIT) ? offset[3:0] : 4'd0;
    end
endmodule

// File: rtl/amp_accum.sv
module amp_accum #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dig_en,
    input  logic [3:0]       digit,
    input  logic             clr,
    output logic [VAL_W-1:0] acc,
    output logic             have
);
    localparam int W = VAL_W + 4;
    localparam logic [W-1:0] TEN  = W'(10);
    localparam logic [W-1:0] VMAX = {4'b0, {VAL_W{1'b1}}};

    logic [W-1:0]     wide;
    logic [VAL_W-1:0] next_val;

    always_comb begin
        wide     = {4'b0, acc} * TEN + {{VAL_W{1'b0}}, digit};
        next_val = (wide > VMAX) ? {VAL_W{1'b1}} : wide[VAL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            have <= 1'b0;
        end else if (clr) begin
            acc  <= '0;
            have <= 1'b0;
        end else if (dig_en) begin
            acc  <= next_val;
            have <= 1'b1;
        end
    end

    // R3: a new digit never makes the running value smaller (saturation, no wrap)
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        $past(dig_en) && !$past(clr) && !$past(rst) |-> acc >= $past(acc));
endmodule

// File: rtl/amp_shape.sv
module amp_shape
    import amp_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  char_class_e       ev,
    input  logic [VAL_W-1:0]  acc,
    input  logic              have,
    output logic              we_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [VAL_W-1:0]  wdata_q,
    output logic [DIM_W-1:0]  cols_q,
    output logic [DIM_W-1:0]  rows_q,
    output logic              done_q,
    output logic              err_q
);
    localparam logic [DIM_W-1:0] DIM_ONE  = DIM_W'(1);
    localparam logic [ADDR_W-1:0] ADR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] wr_ptr;
    logic [DIM_W-1:0]  in_row;
    logic [DIM_W-1:0]  entries;
    logic              closing;

    always_comb begin
        entries = in_row + (have ? DIM_ONE : '0);
        closing = (ev == CC_NL) || (ev == CC_EOF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            in_row  <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            cols_q  <= '0;
            rows_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if ((ev == CC_SEP || closing) && have) begin
                we_q    <= 1'b1;
                addr_q  <= wr_ptr;
                wdata_q <= acc;
                wr_ptr  <= wr_ptr + ADR_ONE;
            end
            if (ev == CC_SEP && have) begin
                in_row <= entries;
            end
            if (closing) begin
                in_row <= '0;
                if (entries != '0) begin
                    rows_q <= rows_q + DIM_ONE;
                    if (cols_q == '0) begin
                        cols_q <= entries;
                    end else if (entries != cols_q) begin
                        err_q <= 1'b1;
                    end
                end
            end
            if (ev == CC_EOF) begin
                done_q <= 1'b1;
            end
            if (ev == CC_BAD) begin
                err_q <= 1'b1;
            end
        end
    end

    // R10: done holds until reset
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);
    // R10: no write once done has been seen for a full cycle
    a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done_q && $past(done_q) |-> !we_q);
    // R7: error is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    // R4: back-to-back writes use consecutive addresses
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        we_q |=> (!we_q || addr_q == $past(addr_q) + ADR_ONE));
    // R5: once latched, the column count never changes
    a_r5_cols_hold: assert property (@(posedge clk) disable iff (rst)
        cols_q != '0 |=> cols_q == $past(cols_q));
    // R5: the row count only grows, and by at most one per cycle
    a_r5_rows_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rows_q == $past(rows_q) || rows_q == $past(rows_q) + DIM_ONE));
endmodule

// File: rtl/ascii_matrix_parser.sv
module ascii_matrix_parser
    import amp_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int ADDR_W = 10,
    parameter int DIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_eos,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VAL_W-1:0]  mem_wdata,
    output logic [DIM_W-1:0]  col_count,
    output logic [DIM_W-1:0]  row_count,
    output logic              done,
    output logic              error
);
    char_class_e      byte_cls;
    char_class_e      ev;
    logic [3:0]       digit;
    logic [VAL_W-1:0] acc;
    logic             have;
    logic             acc_clr;

    amp_classify u_cls (
        .ch    (in_byte),
        .cls   (byte_cls),
        .digit (digit)
    );

    always_comb begin
        if (done)          ev = CC_NONE;
        else if (in_eos)   ev = CC_EOF;
        else if (in_valid) ev = byte_cls;
        else               ev = CC_NONE;
        acc_clr = (ev == CC_SEP) || (ev == CC_NL) || (ev == CC_EOF);
    end

    amp_accum #(.VAL_W(VAL_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .dig_en (ev == CC_DIGIT),
        .digit  (digit),
        .clr    (acc_clr),
        .acc    (acc),
        .have   (have)
    );

    amp_shape #(.VAL_W(VAL_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_shape (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .acc     (acc),
        .have    (have),
        .we_q    (mem_we),
        .addr_q  (mem_addr),
        .wdata_q (mem_wdata),
        .cols_q  (col_count),
        .rows_q  (row_count),
        .done_q  (done),
        .err_q   (error)
    );

    // R9: in_eos while running raises done on the next edge
    a_r9_eos_done: assert property (@(posedge clk) disable iff (rst)
        in_eos |=> done);
endmodule

// File: tb/ascii_matrix_parser_tb.sv
module ascii_matrix_parser_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_eos = 1'b0;
    logic        mem_we;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [7:0]  col_count, row_count;
    logic        done, error;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    int cap_base = 0;
    int cap_addr [0:255];
    int cap_data [0:255];
    bit finished = 0;

    always #5 clk = ~clk;

    ascii_matrix_parser u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_eos(in_eos),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .col_count(col_count), .row_count(row_count), .done(done), .error(error)
    );

    always @(posedge clk) begin
        if (!rst && mem_we && cap_n < 256) begin
            cap_addr[cap_n] = int'(mem_addr);
            cap_data[cap_n] = int'(mem_wdata);
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_eos = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cap_base = cap_n;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic pulse_eos();
        @(negedge clk);
        in_eos = 1'b1;
        @(negedge clk);
        in_eos = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_write(input string req, input int k, input int addr, input int val);
        chk({req, " addr"}, cap_addr[cap_base + k], addr);
        chk({req, " data"}, cap_data[cap_base + k], val);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 we", int'(mem_we), 0);
        chk("R1 addr", int'(mem_addr), 0);
        chk("R1 wdata", int'(mem_wdata), 0);
        chk("R1 cols", int'(col_count), 0);
        chk("R1 rows", int'(row_count), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after release", int'(done), 0);
    endtask

    task automatic t_basic();
        int exp_v [6] = '{1, 2, 3, 40, 5, 600};
        do_reset();
        send_str("1 2 3\n40 5 600\n");
        send_byte(8'h04);
        settle();
        chk("R2 write count", cap_n - cap_base, 6);
        for (int k = 0; k < 6; k++) chk_write("R4 row-major", k, k, exp_v[k]);
        chk("R5 cols", int'(col_count), 3);
        chk("R5 rows", int'(row_count), 2);
        chk("R9 done by 0x04", int'(done), 1);
        chk("R7 no error", int'(error), 0);
    endtask

    task automatic t_pulse_width();
        do_reset();
        send_str("7");
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h2C;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 we high cycle after sep", int'(mem_we), 1);
        chk("R2 wdata", int'(mem_wdata), 7);
        @(negedge clk);
        chk("R2 we single cycle", int'(mem_we), 0);
    endtask

    task automatic t_seps_cr();
        do_reset();
        send_str("10,,20  30\r\n");
        pulse_eos();
        settle();
        chk("R4 empty seps write nothing", cap_n - cap_base, 3);
        chk_write("R4 seps", 2, 2, 30);
        chk("R6 CR ignored cols", int'(col_count), 3);
        chk("R6 CR no error", int'(error), 0);
        chk("R9 done by in_eos", int'(done), 1);
    endtask

    task automatic t_sat();
        do_reset();
        send_str("70000 65535 99\n");
        pulse_eos();
        settle();
        chk_write("R3 saturate", 0, 0, 65535);
        chk_write("R3 max exact", 1, 1, 65535);
        chk_write("R3 small", 2, 2, 99);
    endtask

    task automatic t_mismatch();
        do_reset();
        send_str("1 2\n3\n");
        chk("R7 error on short row", int'(error), 1);
        send_str("4 5\n");
        pulse_eos();
        settle();
        chk("R7 error sticky", int'(error), 1);
        chk("R5 rows with mismatch", int'(row_count), 3);
        chk("R5 cols first row", int'(col_count), 2);
    endtask

    task automatic t_bad();
        do_reset();
        send_str("1a2 3\n");
        pulse_eos();
        settle();
        chk("R8 error on bad char", int'(error), 1);
        chk("R8 writes", cap_n - cap_base, 2);
        chk_write("R8 skipped char joins digits", 0, 0, 12);
    endtask

    task automatic t_empty_lines();
        do_reset();
        send_str("\n\n7\n\n");
        pulse_eos();
        settle();
        chk("R5 empty lines rows", int'(row_count), 1);
        chk("R5 empty lines cols", int'(col_count), 1);
        chk_write("R5 newline stores pending", 0, 0, 7);
    endtask

    task automatic t_eof_pending_and_after();
        do_reset();
        send_str("8 9");
        send_byte(8'h04);
        settle();
        chk("R9 eof stores pending", cap_n - cap_base, 2);
        chk("R9 eof closes row", int'(row_count), 1);
        send_str("5 6\n");
        pulse_eos();
        settle();
        chk("R10 no writes after done", cap_n - cap_base, 2);
        chk("R10 rows hold", int'(row_count), 1);
        chk("R10 cols hold", int'(col_count), 2);
        chk("R10 error holds", int'(error), 0);
    endtask

    task automatic t_eos_priority();
        do_reset();
        send_str("4 ");
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h39; in_eos = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eos = 1'b0;
        settle();
        chk("R9 byte dropped with eos", cap_n - cap_base, 1);
        chk("R9 done with eos", int'(done), 1);
        chk("R9 cols", int'(col_count), 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pulse_width();
        t_seps_cr();
        t_sat();
        t_mismatch();
        t_bad();
        t_empty_lines();
        t_eof_pending_and_after();
        t_eos_priority();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
    end
endmodule